// File: doc/BRIEF.md
# Key-Protected DRAM Controller Register Bank

This block holds the 32-bit control and status registers of a DRAM controller. The registers sit in a 4 KB byte-addressed window, and the block accepts only aligned word accesses through a simple read/write strobe interface. A single protection word guards the bank. Writing one magic value to it opens the bank. Writing a second magic value freezes the bank until the next reset. Writing anything else closes the bank again, but the protection word itself can still be rewritten.

Three test and error-injection registers can always be written, whatever the lock state. The configuration word shows fixed fields that software cannot change, including a field that mirrors the static RAM size input. Two status words force their completion bits on every accepted write, so boot software never waits on a PHY or an ECC test that does not exist here. When the lock state drops a write, the block pulses `write_blocked` for one cycle.

Top module: `dram_ctl_regbank`

## Requirements
- R1: The protection word at byte offset 0x000 reads 0x00000001 (open) after a write of 0xFC600309, 0x00000010 (frozen) after a write of 0xDEADDEAD, and 0x00000000 (closed) after a write of any other value.
- R2: In the frozen state, every write to a non-exempt register is dropped, including writes to the protection word. Only reset leaves the frozen state.
- R3: In the closed state, writes to every non-exempt register other than the protection word are dropped, so the open key can be written again.
- R4: Writes to offsets 0x074, 0x07C and 0x0B4 are always stored, whatever the lock state.
- R5: The configuration word at 0x004 always reads with bits 31:28 = 3 and bits 3:2 = 2'b11. Bits 1:0 equal `ram_size_idx` (256 MB=0, 512 MB=1, 1 GB=2, 2 GB=3). Bits 19:14 and bit 6 read as 0. Writes only change the remaining bits.
- R6: An accepted write to 0x060 stores the data with bit 0 cleared and bit 4 set.
- R7: An accepted write to 0x070 stores the data with bit 12 set and bit 13 cleared.
- R8: After reset, every register reads zero, except the configuration word, which shows its fixed fields, and the protection word, which reads 0x00000001 when `RESET_UNLOCKED`=1 (the default) and 0x00000000 otherwise.
- R9: Two kinds of access have no effect. One is an access beyond the implemented range (word count `NUM_REGS`=64, so offsets 0x000 to 0x0FC). The other is an access with `addr[1:0]` not equal to zero. Such a read returns 0, and such a write changes nothing.
- R10: `write_blocked` is high for exactly the cycle after a write that the lock state dropped. It stays low for accepted, exempt and out-of-range writes.
- R11: `rdata` takes the addressed value on the clock edge where `rd_en` is high, and holds it while `rd_en` is low. A read in the same cycle as a write to the same word returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ram_size_idx | input | 2 | Static RAM size code shown in the configuration word |
| wr_en | input | 1 | Write strobe, committed on the rising edge |
| rd_en | input | 1 | Read strobe |
| addr | input | 12 | Byte address within the 4 KB window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| write_blocked | output | 1 | One-cycle pulse after a write dropped by the lock |

## Verification
A wrong lock state shows up as a protected write that either stores or fails to store. This is visible on the next read of that word, and on `write_blocked` one cycle after the write. A corrupted protection word or fixed configuration field shows up in the very first read of offset 0x000 or 0x004. A bad forced-bit path shows up on the read that follows the write. The bench drives each lock state, an exempt write in each lock state, both magic keys, the last in-range word, and misaligned and out-of-range addresses.

// File: rtl/dram_rb_pkg.sv
package dram_rb_pkg;

  localparam int unsigned DW = 32;

  typedef enum logic [1:0] {
    LK_CLOSED = 2'd0,
    LK_OPEN   = 2'd1,
    LK_FROZEN = 2'd2
  } lock_e;

  localparam logic [DW-1:0] KEY_OPEN   = 32'hFC60_0309;
  localparam logic [DW-1:0] KEY_FREEZE = 32'hDEAD_DEAD;

  // word indices (byte offset / 4)
  localparam int unsigned WI_PROT  = 0;
  localparam int unsigned WI_CONF  = 1;
  localparam int unsigned WI_PHY   = 24;
  localparam int unsigned WI_ECC   = 28;
  localparam int unsigned WI_TLEN  = 29;
  localparam int unsigned WI_TINIT = 31;
  localparam int unsigned WI_INJ   = 45;

  localparam logic [DW-1:0] CONF_RO_MASK = 32'hF00F_C04F;
  localparam logic [3:0]    CONF_VER     = 4'd3;

  function automatic lock_e decode_key(input logic [DW-1:0] d);
    if (d == KEY_OPEN)        return LK_OPEN;
    else if (d == KEY_FREEZE) return LK_FROZEN;
    else                      return LK_CLOSED;
  endfunction

  function automatic logic [DW-1:0] lock_word(input lock_e s);
    case (s)
      LK_OPEN:   return 32'h0000_0001;
      LK_FROZEN: return 32'h0000_0010;
      default:   return 32'h0000_0000;
    endcase
  endfunction

endpackage

// File: rtl/rb_lock_ctrl.sv
module rb_lock_ctrl
  import dram_rb_pkg::*;
#(
  parameter int unsigned IW             = 6,
  parameter bit          RESET_UNLOCKED = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          in_range,
  input  logic [IW-1:0] sel,
  input  logic [DW-1:0] wdata,
  output logic          commit_o,
  output logic          blocked_o,
  output lock_e         state_o
);

  localparam logic [IW-1:0] L_PROT  = IW'(WI_PROT);
  localparam logic [IW-1:0] L_TLEN  = IW'(WI_TLEN);
  localparam logic [IW-1:0] L_TINIT = IW'(WI_TINIT);
  localparam logic [IW-1:0] L_INJ   = IW'(WI_INJ);
  localparam lock_e         RST_ST  = RESET_UNLOCKED ? LK_OPEN : LK_CLOSED;

  lock_e state_q, state_d;
  logic  exempt;

  assign exempt = (sel == L_TLEN) || (sel == L_TINIT) || (sel == L_INJ);

  always_comb begin
    commit_o  = 1'b0;
    blocked_o = 1'b0;
    if (wr_en && in_range) begin
      if (exempt) begin
        commit_o = 1'b1;
      end else begin
        case (state_q)
          LK_OPEN:   commit_o = 1'b1;
          LK_CLOSED: begin
            if (sel == L_PROT) commit_o  = 1'b1;
            else               blocked_o = 1'b1;
          end
          default:   blocked_o = 1'b1;
        endcase
      end
    end
  end

  always_comb begin
    state_d = state_q;
    if (commit_o && (sel == L_PROT)) state_d = decode_key(wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= RST_ST;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

  AST_FROZEN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == LK_FROZEN |=> state_q == LK_FROZEN); // R2

  AST_LOCK_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(state_q)); // R1

endmodule

// File: rtl/rb_write_shaper.sv
module rb_write_shaper
  import dram_rb_pkg::*;
#(
  parameter int unsigned IW = 6
) (
  input  logic [IW-1:0] sel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] shaped_o
);

  localparam logic [IW-1:0] L_CONF = IW'(WI_CONF);
  localparam logic [IW-1:0] L_PHY  = IW'(WI_PHY);
  localparam logic [IW-1:0] L_ECC  = IW'(WI_ECC);

  always_comb begin
    shaped_o = wdata;
    if (sel == L_CONF) begin
      shaped_o = wdata & ~CONF_RO_MASK;
    end else if (sel == L_PHY) begin
      shaped_o[0] = 1'b0;
      shaped_o[4] = 1'b1;
    end else if (sel == L_ECC) begin
      shaped_o[12] = 1'b1;
      shaped_o[13] = 1'b0;
    end
  end

endmodule

// File: rtl/rb_reg_array.sv
module rb_reg_array
  import dram_rb_pkg::*;
#(
  parameter int unsigned NUM_REGS = 64,
  parameter int unsigned IW       = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   commit,
  input  logic [IW-1:0]          sel,
  input  logic [DW-1:0]          wdata,
  output logic [NUM_REGS*DW-1:0] q_flat
);

  logic [NUM_REGS-1:0] we;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
    if (i == WI_PROT) begin : g_none
      assign we[i] = 1'b0;
      assign q_flat[i*DW +: DW] = '0;
    end else begin : g_reg
      logic [DW-1:0] word_q, word_d;
      assign we[i] = commit && (sel == IW'(i));
      always_comb begin
        word_d = word_q;
        if (we[i]) word_d = wdata;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
      end
      assign q_flat[i*DW +: DW] = word_q;
    end
  end

  AST_ONE_WORD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(we)); // R9

endmodule

// File: rtl/dram_ctl_regbank.sv
module dram_ctl_regbank
  import dram_rb_pkg::*;
#(
  parameter int unsigned AW             = 12,
  parameter int unsigned NUM_REGS       = 64,
  parameter bit          RESET_UNLOCKED = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    ram_size_idx,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic          write_blocked
);

  localparam int unsigned   WAW    = AW - 2;
  localparam int unsigned   IW     = $clog2(NUM_REGS);
  localparam logic [WAW-1:0] NREG  = WAW'(NUM_REGS);
  localparam logic [IW-1:0] L_PROT = IW'(WI_PROT);
  localparam logic [IW-1:0] L_CONF = IW'(WI_CONF);
  localparam logic [IW-1:0] L_PHY  = IW'(WI_PHY);
  localparam logic [IW-1:0] L_ECC  = IW'(WI_ECC);

  logic [WAW-1:0]         widx;
  logic [IW-1:0]          sel;
  logic                   in_range;
  logic                   commit, blocked;
  lock_e                  lock_st;
  logic [DW-1:0]          shaped;
  logic [NUM_REGS*DW-1:0] q_flat;
  logic [DW-1:0]          rd_word;
  logic [DW-1:0]          rdata_q, rdata_d;
  logic                   blk_q, blk_d;

  assign widx     = addr[AW-1:2];
  assign sel      = widx[IW-1:0];
  assign in_range = (addr[1:0] == 2'b00) && (widx < NREG);

  rb_lock_ctrl #(.IW(IW), .RESET_UNLOCKED(RESET_UNLOCKED)) u_lock (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .in_range(in_range),
    .sel(sel), .wdata(wdata), .commit_o(commit), .blocked_o(blocked),
    .state_o(lock_st)
  );

  rb_write_shaper #(.IW(IW)) u_shape (
    .sel(sel), .wdata(wdata), .shaped_o(shaped)
  );

  rb_reg_array #(.NUM_REGS(NUM_REGS), .IW(IW)) u_regs (
    .clk(clk), .rst_n(rst_n), .commit(commit), .sel(sel),
    .wdata(shaped), .q_flat(q_flat)
  );

  always_comb begin
    rd_word = '0;
    if (in_range) begin
      if (sel == L_PROT)
        rd_word = lock_word(lock_st);
      else if (sel == L_CONF)
        rd_word = (q_flat[WI_CONF*DW +: DW] & ~CONF_RO_MASK)
                | {CONF_VER, 24'd0, 2'b11, ram_size_idx};
      else
        rd_word = q_flat[sel*DW +: DW];
    end
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd_en) rdata_d = rd_word;
    blk_d = blocked;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      blk_q   <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      blk_q   <= blk_d;
    end
  end

  assign rdata         = rdata_q;
  assign write_blocked = blk_q;

  AST_CONF_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && in_range && sel == L_CONF) |=>
      (rdata[31:28] == CONF_VER && rdata[3:2] == 2'b11 &&
       rdata[19:14] == 6'd0 && !rdata[6])); // R5

  AST_PROT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && in_range && sel == L_PROT) |=>
      ((rdata & ~32'h11) == 32'd0 && $onehot0({rdata[4], rdata[0]}))); // R1

  AST_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !in_range) |=> rdata == 32'd0); // R9

  AST_BLOCK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    write_blocked |-> ($past(wr_en) && $past(in_range))); // R10

  AST_PHY_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && sel == L_PHY) |=>
      (q_flat[WI_PHY*DW + 4] && !q_flat[WI_PHY*DW])); // R6

  AST_ECC_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && sel == L_ECC) |=>
      (q_flat[WI_ECC*DW + 12] && !q_flat[WI_ECC*DW + 13])); // R7

endmodule

// File: tb/dram_ctl_regbank_bench.sv
`timescale 1ns/1ps
module dram_ctl_regbank_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  ram_size_idx;
  logic        wr_en, rd_en;
  logic [11:0] addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        write_blocked;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  dram_ctl_regbank u_dram_ctl_regbank (
    .clk(clk), .rst_n(rst_n), .ram_size_idx(ram_size_idx),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .write_blocked(write_blocked)
  );

  // {addr, write data, expected readback}, bank open
  localparam int NV = 12;
  localparam logic [75:0] VEC [NV] = '{
    {12'h004, 32'hFFFF_FFFF, 32'h3FF0_3FBE},
    {12'h004, 32'h0000_0000, 32'h3000_000E},
    {12'h060, 32'hFFFF_FFFF, 32'hFFFF_FFFE},
    {12'h060, 32'h0000_0000, 32'h0000_0010},
    {12'h070, 32'hFFFF_FFFF, 32'hFFFF_DFFF},
    {12'h070, 32'h0000_0000, 32'h0000_1000},
    {12'h008, 32'hA5A5_A5A5, 32'hA5A5_A5A5},
    {12'h074, 32'h1234_5678, 32'h1234_5678},
    {12'h100, 32'hDEAD_BEEF, 32'h0000_0000},
    {12'h0FC, 32'h0000_FFFF, 32'h0000_FFFF},
    {12'h00A, 32'h5A5A_5A5A, 32'h0000_0000},
    {12'h000, 32'hFC60_0309, 32'h0000_0001}
  };

  function automatic string row_tag(input int i);
    case (i)
      0, 1:    return "R5";
      2, 3:    return "R6";
      4, 5:    return "R7";
      6, 7:    return "R4";
      8, 9,
      10:      return "R9";
      default: return "R1";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    v = rdata;
    rd_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(8ns * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; ram_size_idx = 2'd2;
    wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state R8
    rd(12'h000, v); check("R8 prot", v, 32'h1);
    rd(12'h004, v); check("R8 conf", v, 32'h3000_000E);
    rd(12'h008, v); check("R8 word", v, 32'h0);
    check("R10 idle", {31'd0, write_blocked}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][75:64], VEC[i][63:32]);
      check({row_tag(i), " R10 no block"}, {31'd0, write_blocked}, 32'h0);
      rd(VEC[i][75:64], v);
      check(row_tag(i), v, VEC[i][31:0]);
    end
    rd(12'h008, v); check("R9 misaligned write ignored", v, 32'hA5A5_A5A5);

    // R11 hold while rd_en low
    @(negedge clk); addr = 12'h004;
    @(negedge clk); check("R11 hold", rdata, 32'hA5A5_A5A5);

    // closed state
    wr(12'h000, 32'h1111_1111);
    rd(12'h000, v); check("R1 closed", v, 32'h0);
    wr(12'h008, 32'h0000_0001);
    check("R10 pulse", {31'd0, write_blocked}, 32'h1);
    @(negedge clk);
    check("R10 one cycle", {31'd0, write_blocked}, 32'h0);
    rd(12'h008, v); check("R3 dropped", v, 32'hA5A5_A5A5);
    wr(12'h07C, 32'h0000_CAFE);
    check("R4 no block", {31'd0, write_blocked}, 32'h0);
    rd(12'h07C, v); check("R4 exempt closed", v, 32'h0000_CAFE);
    wr(12'h000, 32'hFC60_0309);
    rd(12'h000, v); check("R3 reopen", v, 32'h1);

    // frozen state
    wr(12'h000, 32'hDEAD_DEAD);
    rd(12'h000, v); check("R1 frozen", v, 32'h10);
    wr(12'h000, 32'hFC60_0309);
    check("R2 key blocked", {31'd0, write_blocked}, 32'h1);
    rd(12'h000, v); check("R2 still frozen", v, 32'h10);
    wr(12'h0B4, 32'h0000_BEEF);
    rd(12'h0B4, v); check("R4 exempt frozen", v, 32'h0000_BEEF);
    wr(12'h008, 32'h0);
    check("R2 blocked", {31'd0, write_blocked}, 32'h1);
    rd(12'h008, v); check("R2 dropped", v, 32'hA5A5_A5A5);

    // reset leaves frozen
    do_reset();
    rd(12'h000, v); check("R2 reset exit", v, 32'h1);
    rd(12'h008, v); check("R8 cleared", v, 32'h0);
    rd(12'h004, v); check("R8 conf again", v, 32'h3000_000E);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule